// File: doc/BRIEF.md
# Serial Control Command Frame Parser

This block sits behind a byte-wide serial slave front end and interprets the control transactions it delivers. A transaction runs while the active-low select `cs_n` is held low. The first byte is a command. Depending on that command, a 16-bit big-endian start address follows. The rest of the frame is payload, carried as words of 1, 3, 4 or 5 bytes. The command picks the target area: program RAM, coefficient RAM, offset registers, control registers, power registers or monitor registers. It also picks the direction and the word width.

For writes, each complete word is presented once on `wr_data`, right-justified, with a one-cycle `wr_en` strobe. For reads, the block holds `rd_req` until the target answers with `rd_ack` and `rd_data`, right-justified. It then returns the word on `tx_byte`, most significant byte first, one byte for each dummy byte the host clocks in. In the RAM areas, consecutive words go to consecutive addresses. Register areas take or give exactly one word. Codes outside the defined set raise a sticky error flag, and the rest of the frame is ignored.

Top module: `ctl_frame_parser`

## Requirements
- R1: After reset, `wr_en`, `rd_req` and `cmd_err` are 0 and `tx_byte` is 0x00.
- R2: Command 0xB8 writes program RAM (area code 0). Two address bytes (high, low) follow, then 5-byte words. For each word, one cycle after its last byte is taken, `wr_en` is high for exactly one cycle, `wr_addr` holds the word address, `area`=0, and `wr_data` holds the 40 bits with the first byte received in bits 39:32.
- R3: Commands 0xB4 (coefficient RAM, area 1) and 0xB2 (offset registers, area 2) take two address bytes and then 3-byte words. `wr_data` bits 23:0 hold the word with the first byte in bits 23:16, and bits 39:24 are 0.
- R4: In areas 0 to 2, each following word in a frame, for reads and for writes, uses the previous word's address plus 1, modulo 2^16.
- R5: Commands 0xC0 to 0xC8, except 0xC7, write one control register (area 3) with no address bytes. `wr_addr` is the command's low nibble and `wr_data` bits 7:0 hold the payload byte. Any payload bytes after the first produce no write.
- R6: Commands 0xD0 and 0xD1 write one power register (area 4). `wr_addr` is the command's bit 0. One 8-bit word is taken, and later bytes produce no write.
- R7: Reads: 0x38 (area 0, 5-byte words), 0x34 (area 1, 3 bytes) and 0x32 (area 2, 3 bytes) take two address bytes. 0x40 to 0x48 except 0x47 read one control-register byte at index = low nibble. 0x50 and 0x51 read one power-register byte at index = bit 0. `rd_req` stays high, with `rd_addr` and `area` stable, until `rd_ack`.
- R8: Commands 0x76, 0x78, 0x7A and 0x7C read one 32-bit monitor word (area 5) at index 0, 1, 2 and 3. The word carries 28 data bits at the top and 4 validity flags at the bottom.
- R9: Read words go out on `tx_byte` most significant byte first. From the cycle after `rd_ack`, `tx_byte` shows the current byte, and each `rx_valid` moves on to the next byte. Only the low 8×width bits of `rd_data` are used. When a one-word read area is used up, `tx_byte` is 0x00.
- R10: Any other command code sets `cmd_err`, which stays set until reset. No `wr_en` or `rd_req` is issued for the rest of that frame.
- R11: Raising `cs_n` ends the frame at once. A partly received word is dropped without a write, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to send for the current read position |
| area | output | 3 | Target area code of the current frame |
| wr_en | output | 1 | Write strobe, one cycle per word |
| wr_addr | output | 16 | Write address |
| wr_data | output | 40 | Write word, right-justified |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 16 | Read address |
| rd_ack | input | 1 | Read acknowledge, with `rd_data` valid |
| rd_data | input | 40 | Read word, right-justified |
| cmd_err | output | 1 | Sticky flag: an illegal command was seen |

## Verification
A write strobe is due in the cycle after the clock edge that takes a word's last byte. A monitor samples on falling edges and logs every strobe, and the whole log is compared with the expected list after `cs_n` rises. A read request appears one edge after the command or the address low byte is taken. The responding target acknowledges on the next falling edge, and the byte is on `tx_byte` one edge later. The bench therefore waits three falling edges before it samples each read byte and only then sends the next dummy byte. After the last byte of a RAM word, the same wait covers the new request and its reply.

// File: rtl/ctl_frame_parser.sv
module ctl_frame_parser #(
  parameter int AW = 16,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic [7:0]    tx_byte,
  output logic [2:0]    area,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          cmd_err
);
  localparam int WB = DW / 8;

  typedef enum logic [2:0] {S_CMD, S_AHI, S_ALO, S_WR, S_RQ, S_RS, S_IGN, S_BAD} st_t;
  st_t st;

  logic [2:0]    nb, bc;
  logic          wdir;
  logic [AW-1:0] addr;
  logic [DW-1:0] acc;

  logic          d_ok, d_wr, d_adr;
  logic [2:0]    d_area, d_nb;
  logic [AW-1:0] d_idx;

  always_comb begin
    d_ok = 1'b1; d_wr = 1'b0; d_adr = 1'b0; d_area = 3'd0; d_nb = 3'd1; d_idx = '0;
    case (rx_byte)
      8'hB8: begin d_wr = 1'b1; d_adr = 1'b1; d_area = 3'd0; d_nb = 3'd5; end
      8'hB4: begin d_wr = 1'b1; d_adr = 1'b1; d_area = 3'd1; d_nb = 3'd3; end
      8'hB2: begin d_wr = 1'b1; d_adr = 1'b1; d_area = 3'd2; d_nb = 3'd3; end
      8'h38: begin d_adr = 1'b1; d_area = 3'd0; d_nb = 3'd5; end
      8'h34: begin d_adr = 1'b1; d_area = 3'd1; d_nb = 3'd3; end
      8'h32: begin d_adr = 1'b1; d_area = 3'd2; d_nb = 3'd3; end
      8'h76, 8'h78, 8'h7A, 8'h7C: begin
        d_area = 3'd5; d_nb = 3'd4;
        d_idx = AW'(rx_byte[3:1] - 3'd3);
      end
      default: begin
        if (rx_byte[3:0] <= 4'd8 && rx_byte[3:0] != 4'd7 &&
            (rx_byte[7:4] == 4'hC || rx_byte[7:4] == 4'h4)) begin
          d_wr = rx_byte[7]; d_area = 3'd3; d_idx = AW'(rx_byte[3:0]);
        end else if (rx_byte[7:1] == 7'b1101000 || rx_byte[7:1] == 7'b0101000) begin
          d_wr = rx_byte[7]; d_area = 3'd4; d_idx = AW'(rx_byte[0]);
        end else begin
          d_ok = 1'b0;
        end
      end
    endcase
  end

  wire ram = (area <= 3'd2);
  wire last = (bc == nb - 3'd1);

  assign rd_req  = (st == S_RQ) && !cs_n;
  assign rd_addr = addr;
  assign tx_byte = (st == S_RS) ? acc[DW-1 -: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; nb <= 3'd1; bc <= 3'd0; wdir <= 1'b0; addr <= '0; acc <= '0;
      area <= 3'd0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; cmd_err <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cs_n) begin
        st <= S_CMD;
        bc <= 3'd0;
      end else begin
        case (st)
          S_CMD: if (rx_valid) begin
            area <= d_area; nb <= d_nb; wdir <= d_wr; addr <= d_idx;
            bc <= 3'd0; acc <= '0;
            if (!d_ok) begin
              cmd_err <= 1'b1;
              st <= S_BAD;
            end else if (d_adr) st <= S_AHI;
            else st <= d_wr ? S_WR : S_RQ;
          end
          S_AHI: if (rx_valid) begin
            addr[AW-1 -: 8] <= rx_byte;
            st <= S_ALO;
          end
          S_ALO: if (rx_valid) begin
            addr[7:0] <= rx_byte;
            st <= wdir ? S_WR : S_RQ;
          end
          S_WR: if (rx_valid) begin
            if (last) begin
              bc <= 3'd0;
              acc <= '0;
              wr_en <= 1'b1;
              wr_addr <= addr;
              wr_data <= {acc[DW-9:0], rx_byte};
              if (ram) addr <= addr + 1'b1;
              else st <= S_IGN;
            end else begin
              bc <= bc + 3'd1;
              acc <= {acc[DW-9:0], rx_byte};
            end
          end
          S_RQ: if (rd_ack) begin
            acc <= rd_data << (6'(WB) - 6'(nb)) * 6'd8;
            bc <= 3'd0;
            st <= S_RS;
          end
          S_RS: if (rx_valid) begin
            acc <= acc << 8;
            if (last) begin
              bc <= 3'd0;
              if (ram) begin
                addr <= addr + 1'b1;
                st <= S_RQ;
              end else st <= S_IGN;
            end else bc <= bc + 3'd1;
          end
          default: ;
        endcase
      end
    end
  end

  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (cs_n || (rd_req && $stable(rd_addr) && $stable(area))));
  p_mon_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && area == 3'd5) |-> (rd_addr < 4));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  p_frame_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!wr_en && !rd_req));
endmodule

// File: tb/ctl_frame_parser_bench.sv
module ctl_frame_parser_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0, rd_ack = 1'b0;
  logic [7:0] rx_byte = 8'h00, tx_byte;
  logic [2:0] area;
  logic wr_en, rd_req, cmd_err;
  logic [15:0] wr_addr, rd_addr;
  logic [39:0] wr_data, rd_data = '0;

  int checks = 0, fails = 0, rd_n = 0, lg_n = 0;
  bit err_exp = 0;
  logic [2:0] lg_area [64];
  logic [15:0] lg_addr [64];
  logic [39:0] lg_data [64];
  logic [2:0] ex_area [64];
  logic [15:0] ex_addr [64];
  logic [39:0] ex_data [64];
  int ex_n;

  ctl_frame_parser u_ctl_frame_parser (.clk, .rst_n, .cs_n, .rx_valid, .rx_byte, .tx_byte,
    .area, .wr_en, .wr_addr, .wr_data, .rd_req, .rd_addr, .rd_ack, .rd_data, .cmd_err);

  always #2.5 clk = ~clk;

  function automatic logic [39:0] tgt(input logic [2:0] a, input logic [15:0] ad);
    return {a, 5'h15, ad, ad ^ 16'hA5C3};
  endfunction

  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack <= 1'b1; rd_data <= tgt(area, rd_addr); rd_n++;
    end else rd_ack <= 1'b0;
    if (wr_en && lg_n < 64) begin
      lg_area[lg_n] = area; lg_addr[lg_n] = wr_addr; lg_data[lg_n] = wr_data; lg_n++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void dec(input logic [7:0] c, output bit ok, output bit wr, output bit ha,
                              output int ar, output int nb, output int idx);
    ok = 1; wr = 0; ha = 0; ar = 0; nb = 1; idx = 0;
    if (c == 8'hB8 || c == 8'h38) begin wr = (c == 8'hB8); ha = 1; ar = 0; nb = 5; end
    else if (c == 8'hB4 || c == 8'h34) begin wr = (c == 8'hB4); ha = 1; ar = 1; nb = 3; end
    else if (c == 8'hB2 || c == 8'h32) begin wr = (c == 8'hB2); ha = 1; ar = 2; nb = 3; end
    else if ((c[7:4] == 4'hC || c[7:4] == 4'h4) && c[3:0] <= 8 && c[3:0] != 7) begin
      wr = c[7]; ar = 3; idx = int'(c[3:0]);
    end else if (c == 8'hD0 || c == 8'hD1 || c == 8'h50 || c == 8'h51) begin
      wr = c[7]; ar = 4; idx = int'(c[0]);
    end else if (c == 8'h76) begin ar = 5; nb = 4; idx = 0; end
    else if (c == 8'h78) begin ar = 5; nb = 4; idx = 1; end
    else if (c == 8'h7A) begin ar = 5; nb = 4; idx = 2; end
    else if (c == 8'h7C) begin ar = 5; nb = 4; idx = 3; end
    else ok = 0;
  endfunction

  task automatic snd(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic frame(input logic [7:0] c, input logic [15:0] a, input int nbytes, input string tag);
    bit ok, wr, ha; int ar, nb, idx, rd0;
    logic [39:0] w; logic [15:0] wa;
    dec(c, ok, wr, ha, ar, nb, idx);
    lg_n = 0; ex_n = 0; rd0 = rd_n; w = '0;
    @(negedge clk); cs_n = 1'b0;
    snd(c);
    if (ok && ha) begin snd(a[15:8]); snd(a[7:0]); end
    wa = ha ? a : 16'(idx);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = 8'($urandom);
      int wi = i / nb, bj = i % nb;
      logic [15:0] ad = wa + 16'(wi);
      bit live = ok && (ar <= 2 || wi == 0);
      if (ok && !wr) begin
        logic [39:0] v = tgt(3'(ar), ad);
        logic [7:0] eb = live ? v[8*(nb-1-bj) +: 8] : 8'h00;
        repeat (3) @(negedge clk);
        chk($sformatf("R9 %s tx byte %0d", tag, i), 64'(tx_byte), 64'(eb));
      end
      snd(b);
      if (ok && wr) begin
        w = {w[31:0], b};
        if (bj == nb - 1 && live) begin
          ex_area[ex_n] = 3'(ar); ex_addr[ex_n] = ad; ex_data[ex_n] = w; ex_n++;
        end
        if (bj == nb - 1) w = '0;
      end
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    if (!ok) begin
      err_exp = 1;
      chk($sformatf("R10 %s no read request", tag), 64'(rd_n - rd0), 64'd0);
    end
    chk($sformatf("R10 %s cmd_err", tag), 64'(cmd_err), 64'(err_exp));
    chk($sformatf("R11 %s write count", tag), 64'(lg_n), 64'(ex_n));
    for (int k = 0; k < ex_n && k < lg_n; k++)
      chk($sformatf("R2 R3 R4 R5 R6 %s write %0d", tag, k),
          {5'd0, lg_area[k], lg_addr[k], lg_data[k]}, {5'd0, ex_area[k], ex_addr[k], ex_data[k]});
  endtask

  logic [7:0] legal [28] = '{8'hB8, 8'hB4, 8'hB2, 8'hC0, 8'hC3, 8'hC6, 8'hC8, 8'hD0, 8'hD1,
    8'h38, 8'h34, 8'h32, 8'h40, 8'h41, 8'h45, 8'h46, 8'h48, 8'h50, 8'h51, 8'h76, 8'h78,
    8'h7A, 8'h7C, 8'hC1, 8'h42, 8'hC5, 8'h44, 8'hC2};

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 reset outputs", {wr_en, rd_req, cmd_err, tx_byte}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 after release", {wr_en, rd_req, cmd_err, tx_byte}, 64'd0);
    frame(8'hB8, 16'hFFFF, 10, "R2 pram two words wrap R4");
    frame(8'hB4, 16'h0100, 9, "R3 cram");
    frame(8'hB2, 16'h0200, 4, "R11 oreg partial");
    frame(8'hC8, 16'h0, 3, "R5 reg8 extra ignored");
    frame(8'hD1, 16'h0, 2, "R6 pwr1");
    frame(8'h38, 16'h1234, 10, "R7 pram read R4");
    frame(8'h34, 16'h00FF, 6, "R7 cram read");
    frame(8'h45, 16'h0, 2, "R7 reg read");
    frame(8'h51, 16'h0, 1, "R7 pwr read");
    frame(8'h7A, 16'h0, 5, "R8 mon2");
    frame(8'h7C, 16'h0, 4, "R8 mon3");
    frame(8'hC7, 16'h0, 3, "R10 c7 illegal");
    frame(8'hB4, 16'h0300, 3, "R10 after error");
    frame(8'h47, 16'h0, 2, "R10 47 illegal");
    for (int n = 0; n < 60; n++) begin
      logic [7:0] c = ($urandom % 5 == 0) ? 8'($urandom) : legal[$urandom % 28];
      frame(c, 16'($urandom), int'($urandom % 12), $sformatf("rand%0d c%0h", n, c));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule